// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block picks the physical frame to give up when a page fault needs a free frame. It keeps one referenced bit per frame and a hand pointer that walks the frames as a ring. The hand rests on the frame that has been resident the longest. Memory references, reported on a separate port, set the bit of the frame they touched.

A victim request starts a sweep that looks at one frame per clock. If the frame under the hand has its bit set, the sweep clears the bit and moves the hand on, which gives that frame a second chance. If the bit is clear, that frame becomes the victim. The block then reports the frame index with a one-cycle done pulse and moves the hand one step past the victim, because the refilled frame is now the newest. A sweep never takes more than N+1 inspections, even when references keep arriving while it runs.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset all referenced bits are 0, the hand is at frame 0 and `doneValid` is low, so the first request returns frame 0 one cycle after it is accepted.
- R2: A reference (`refValid` high with frame index `refFrame`) sets that frame's referenced bit to 1 at the next clock edge.
- R3: During a sweep, if the frame under the hand has its bit at 1, the sweep clears that bit, moves the hand to the next frame and does not choose the frame.
- R4: During a sweep, if the frame under the hand has its bit at 0, that frame is returned on `victimFrame` as the victim.
- R5: After a victim is chosen, the hand points at the frame that follows the victim. Frame N-1 is followed by frame 0, so the next sweep starts there.
- R6: The sweep inspects exactly one frame per clock. `doneValid` rises exactly k cycles after the request is accepted, where k-1 is the number of frames skipped. `doneValid` is high for a single cycle, and `victimFrame` is always below N while it is high.
- R7: A sweep makes at most N+1 inspections. If the (N+1)-th inspection is reached, the frame under the hand is chosen whatever its bit, and that frame is the one the sweep started on.
- R8: If a reference to a frame arrives in the same cycle that the sweep clears that frame's bit, the reference wins and the bit stays at 1.
- R9: A request that is asserted while a sweep is running is ignored: it produces no second done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| refValid | input | 1 | A reference to frame `refFrame` occurs this cycle |
| refFrame | input | $clog2(NUM_FRAMES) | Index of the referenced frame |
| reqValid | input | 1 | Request for a victim; accepted only when no sweep is running |
| doneValid | output | 1 | One-cycle pulse: `victimFrame` holds the chosen frame |
| victimFrame | output | $clog2(NUM_FRAMES) | Index of the chosen victim frame |

## Verification
The assertions check four things on every cycle: the done pulse is one cycle wide and carries an index in range, a reference always leaves its bit set on the next cycle (even against a clear), a sweep never stays busy for more than N+1 cycles, and the hand sits one past the victim when done is reported. Only the bench scenarios can show which frame is chosen and after how many cycles. It compares each request against a reference model of the ring for random reference patterns. It also runs directed cases: the wrap from the last frame to frame 0, a reference that collides with a clear, a sweep forced to its bound by references that keep coming, and a request made while a sweep is busy.

// File: rtl/clock_victim_pkg.sv
package clock_victim_pkg;

  // Strobes from the sweep control to the frame datapath
  typedef struct packed {
    logic clearCur;     // clear the referenced bit under the hand
    logic advance;      // step the hand to the next frame
    logic latchVictim;  // capture the hand as the victim index
  } ctlStrobe_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } sweepState_t;

endpackage

// File: rtl/clock_victim_dp.sv
module clock_victim_dp
  import clock_victim_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  refValid,
  input  logic [IDX_W-1:0]      refFrame,
  input  ctlStrobe_t            strb,
  output logic                  curBit,
  output logic [IDX_W-1:0]      hand,
  output logic [IDX_W-1:0]      victimReg,
  output logic [NUM_FRAMES-1:0] refBits
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

  logic [NUM_FRAMES-1:0] setHit;
  logic [NUM_FRAMES-1:0] clrHit;

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    assign setHit[g] = refValid && (refFrame == IDX_W'(g));
    assign clrHit[g] = strb.clearCur && (hand == IDX_W'(g));
  end

  assign curBit = refBits[hand];

  // a set from a reference overrides a clear from the sweep
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refBits <= '0;
    end else begin
      refBits <= (refBits & ~clrHit) | setHit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hand <= '0;
    end else if (strb.advance) begin
      hand <= (hand == LAST_IDX) ? '0 : hand + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      victimReg <= '0;
    end else if (strb.latchVictim) begin
      victimReg <= hand;
    end
  end

endmodule

// File: rtl/clock_victim_ctl.sv
module clock_victim_ctl
  import clock_victim_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  localparam int CNT_W = $clog2(NUM_FRAMES + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       curBit,
  output ctlStrobe_t strb,
  output logic       sweeping,
  output logic       doneValid
);

  localparam logic [CNT_W-1:0] FORCE_AT = CNT_W'(NUM_FRAMES);

  sweepState_t      state;
  sweepState_t      stateNext;
  logic [CNT_W-1:0] sweepCnt;
  logic             forcePick;

  assign sweeping  = (state == ST_SWEEP);
  assign forcePick = (sweepCnt == FORCE_AT);

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) stateNext = ST_SWEEP;
      end
      ST_SWEEP: begin
        strb.clearCur = 1'b1;
        strb.advance  = 1'b1;
        if (!curBit || forcePick) begin
          strb.latchVictim = 1'b1;
          stateNext        = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sweepCnt  <= '0;
      doneValid <= 1'b0;
    end else begin
      state     <= stateNext;
      doneValid <= strb.latchVictim;
      if (state == ST_IDLE) begin
        sweepCnt <= '0;
      end else if (!forcePick) begin
        sweepCnt <= sweepCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel
  import clock_victim_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refValid,
  input  logic [IDX_W-1:0] refFrame,
  input  logic             reqValid,
  output logic             doneValid,
  output logic [IDX_W-1:0] victimFrame
);

  ctlStrobe_t            strb;
  logic                  curBit;
  logic                  sweeping;
  logic [IDX_W-1:0]      hand;
  logic [NUM_FRAMES-1:0] refBits;

  clock_victim_ctl #(.NUM_FRAMES(NUM_FRAMES)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .curBit    (curBit),
    .strb      (strb),
    .sweeping  (sweeping),
    .doneValid (doneValid)
  );

  clock_victim_dp #(.NUM_FRAMES(NUM_FRAMES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .refValid  (refValid),
    .refFrame  (refFrame),
    .strb      (strb),
    .curBit    (curBit),
    .hand      (hand),
    .victimReg (victimFrame),
    .refBits   (refBits)
  );

endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = $clog2(NUM_FRAMES),
  localparam int CNT_W = $clog2(NUM_FRAMES + 2)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  refValid,
  input logic [IDX_W-1:0]      refFrame,
  input logic                  doneValid,
  input logic [IDX_W-1:0]      victimFrame,
  input logic                  sweeping,
  input logic [IDX_W-1:0]      hand,
  input logic [NUM_FRAMES-1:0] refBits
);

  logic [CNT_W-1:0] busyCnt;
  logic [IDX_W-1:0] handAfter;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         busyCnt <= '0;
    else if (sweeping) busyCnt <= busyCnt + 1'b1;
    else               busyCnt <= '0;
  end

  assign handAfter = (victimFrame == IDX_W'(NUM_FRAMES - 1)) ? '0 : victimFrame + 1'b1;

  // R6
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R6
  victim_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (int'(victimFrame) < NUM_FRAMES));

  // R2 R8
  ref_sets_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    refValid |=> refBits[$past(refFrame)]);

  // R7
  sweep_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    sweeping |-> (int'(busyCnt) <= NUM_FRAMES));

  // R5
  hand_past_victim_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (hand == handAfter));

endmodule

bind clock_victim_sel clock_victim_sel_chk #(.NUM_FRAMES(NUM_FRAMES)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .refValid    (refValid),
  .refFrame    (refFrame),
  .doneValid   (doneValid),
  .victimFrame (victimFrame),
  .sweeping    (sweeping),
  .hand        (hand),
  .refBits     (refBits)
);

// File: tb/clock_victim_sel_bench.sv
module clock_victim_sel_bench;

  localparam int N        = 8;
  localparam int IDX_W    = $clog2(N);
  localparam int CLK_HALF = 5;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             refValid = 1'b0;
  logic [IDX_W-1:0] refFrame = '0;
  logic             reqValid = 1'b0;
  logic             doneValid;
  logic [IDX_W-1:0] victimFrame;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  bit mBits[N];
  int mHand;

  clock_victim_sel #(.NUM_FRAMES(N)) u_clock_victim_sel (
    .clk         (clk),
    .rstN        (rstN),
    .refValid    (refValid),
    .refFrame    (refFrame),
    .reqValid    (reqValid),
    .doneValid   (doneValid),
    .victimFrame (victimFrame)
  );

  always #(CLK_HALF) clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference model of one sweep with no references during it
  task automatic predict(output int victim, output int lat);
    for (int i = 0; ; i++) begin
      if (mBits[mHand] && i < N) begin
        mBits[mHand] = 1'b0;
        mHand = (mHand + 1) % N;
      end else begin
        victim = mHand;
        mBits[mHand] = 1'b0;
        mHand = (mHand + 1) % N;
        lat = i + 1;
        break;
      end
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    refValid = 1'b0;
    reqValid = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < N; i++) mBits[i] = 1'b0;
    mHand = 0;
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic doRef(input int f);
    refValid = 1'b1;
    refFrame = IDX_W'(f);
    @(negedge clk);
    refValid = 1'b0;
    mBits[f] = 1'b1;
  endtask

  // request; againAt > 0 pulses reqValid once more during the sweep
  task automatic doRequest(input string req, input int againAt);
    int expV;
    int expLat;
    int lat;
    bit got;
    predict(expV, expLat);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 0;
    got = 1'b0;
    while (!got && lat < N + 4) begin
      reqValid = (againAt > 0 && lat == againAt);
      @(negedge clk);
      reqValid = 1'b0;
      lat++;
      if (doneValid) got = 1'b1;
    end
    check({req, " victim"}, int'(victimFrame), expV);
    check({req, " latency"}, lat, expLat);
    @(negedge clk);
    check("R6 done pulse width", int'(doneValid), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    doReset();
    // R1 reset state
    check("R1 done low after reset", int'(doneValid), 0);
    check("R1 victim index after reset", int'(victimFrame), 0);
    doRequest("R1 first request", 0);

    // R4 R5: plain requests walk the ring and wrap from N-1 to 0
    for (int i = 0; i < N; i++) doRequest("R4 R5 ring walk", 0);

    // R2 R3: referenced frames are skipped and cleared
    doReset();
    doRef(0);
    doRef(1);
    doRef(3);
    doRequest("R2 R3 skip referenced", 0);
    doRequest("R3 bits cleared by sweep", 0);

    // R8: reference collides with the clear of frame 0
    doReset();
    doRef(0);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    refValid = 1'b1;
    refFrame = '0;
    @(negedge clk);
    refValid = 1'b0;
    @(negedge clk);
    check("R8 collide done", int'(doneValid), 1);
    check("R8 collide victim", int'(victimFrame), 1);
    mBits[0] = 1'b1;
    mBits[1] = 1'b0;
    mHand = 2;
    for (int f = 2; f < N; f++) doRef(f);
    doRequest("R8 bit kept after clear", 0);

    // R7: references keep hitting the inspected frame, sweep is forced
    doReset();
    for (int f = 0; f < N; f++) doRef(f);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    begin
      int lat;
      bit got;
      lat = 0;
      got = 1'b0;
      while (!got && lat < N + 4) begin
        refValid = 1'b1;
        refFrame = IDX_W'(lat % N);
        @(negedge clk);
        refValid = 1'b0;
        lat++;
        if (doneValid) got = 1'b1;
      end
      check("R7 forced latency", lat, N + 1);
      check("R7 forced victim", int'(victimFrame), 0);
    end
    for (int f = 0; f < N; f++) mBits[f] = 1'b1;
    mHand = 1;
    @(negedge clk);
    doRequest("R7 R6 full skip", 0);

    // R9: request during a sweep is ignored
    doReset();
    for (int f = 0; f < N; f++) doRef(f);
    doRequest("R9 long sweep", 2);
    begin
      int extra;
      extra = 0;
      for (int k = 0; k < N + 3; k++) begin
        @(negedge clk);
        if (doneValid) extra++;
      end
      check("R9 no extra done", extra, 0);
    end

    // random mix, R2 R3 R4 R5 R6
    doReset();
    for (int it = 0; it < 60; it++) begin
      int nref;
      nref = $urandom_range(0, N + 2);
      for (int k = 0; k < nref; k++) doRef($urandom_range(0, N - 1));
      doRequest("R6 random", 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule